// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge and End-of-Interrupt Interface

This block sits between an interrupt distributor and one processing element. The distributor offers its best pending candidate (ID, priority, group). The block decides whether the candidate may interrupt the processor: its group's signalling must be enabled, its priority must beat the priority mask, and it must be strictly higher than the running priority. When all of these hold and there is room to track one more interrupt, it raises `irq_out`. A lower numeric value is a higher priority.

Software talks to the block through five one-cycle strobes. An acknowledge read returns the interrupt ID, or the spurious ID 1023. An end-of-interrupt write carries an ID. A deactivate write also carries an ID. A mask write sets the priority mask. A control write sets the group enables and the end-of-interrupt mode, and it can clear the error flag. An accepted acknowledge does three things: it pushes the interrupt's priority onto a running-priority stack that is `DEPTH` entries deep, it records the ID as active, and it pulses an acknowledge event to the distributor. Ending an interrupt has two separate parts. The priority drop pops the stack, which brings back the running priority that held before the acknowledge. Deactivation frees the active record and pulses a deactivate event to the distributor. In combined mode one end-of-interrupt write performs both parts. In split mode the end-of-interrupt write only drops the priority, and a later deactivate write performs the deactivation.

The stack occupancy is held by a state machine with three states: `ST_EMPTY`, `ST_PART` and `ST_FULL`.
- An acknowledge moves `ST_EMPTY` to `ST_PART`, or to `ST_FULL` when `DEPTH` is 1.
- An acknowledge moves `ST_PART` to `ST_FULL` when it fills the last entry.
- A drop moves `ST_PART` to `ST_EMPTY` when it removes the last entry.
- A drop moves `ST_FULL` to `ST_PART`, or to `ST_EMPTY` when `DEPTH` is 1.
- Every other cycle holds the state.

Only one access is taken per cycle. An acknowledge read takes precedence over an end-of-interrupt write, and an end-of-interrupt write takes precedence over a deactivate write; a strobe that loses is discarded. Mask and control writes apply alongside any other access.

Top module: `cpuif_ack_eoi`

## Requirements
- R1: After reset `irq_out` is 0, `run_prio` is 0xFF (idle), `err_flag` is 0, the mask is 0x00, both groups are disabled and combined mode is selected.
- R2: `irq_out` is asserted only when `hp_valid` is 1 and the enable of the candidate's group is 1. The group enables are `ctl_wdata[0]` for group 0 and `ctl_wdata[1]` for group 1, and `hp_group` selects the group.
- R3: `irq_out` requires `hp_prio` to be strictly less than the mask written through `pmr_wdata`. A priority equal to the mask is blocked.
- R4: `irq_out` requires `hp_prio` to be strictly less than `run_prio`. A candidate of equal priority does not preempt.
- R5: An acknowledge read taken while `irq_out` is 1 gives the following results one cycle later. `ack_rvalid` is 1 and `ack_rdata` equals `hp_id`. `dist_ack_vld` pulses with `dist_ack_id` equal to `hp_id`. `run_prio` becomes `hp_prio`.
- R6: An acknowledge read taken while `irq_out` is 0 returns `ack_rdata` = 1023 one cycle later, gives no `dist_ack_vld` pulse and leaves `run_prio` unchanged.
- R7: In combined mode (`ctl_wdata[2]` = 0), an end-of-interrupt write whose ID matches the most recent unended acknowledge does two things one cycle later: it drops the running priority and it pulses `dist_deact_vld` with that ID.
- R8: In split mode (`ctl_wdata[2]` = 1), a matching end-of-interrupt write drops the running priority and gives no deactivate pulse. A later deactivate write for that ID pulses `dist_deact_vld` with that ID.
- R9: Some deactivate writes have no effect: a write for an ID that is not active, a write made in combined mode, and a second write for an ID already deactivated. None of these pulses `dist_deact_vld`.
- R10: An end-of-interrupt write whose ID does not match the top of the stack is ignored, and so is one made while the stack is empty. In both cases `run_prio` is kept and `err_flag` is set. `err_flag` stays at 1 until a control write with `ctl_wdata[3]` = 1.
- R11: Acknowledge is suppressed in two cases: when all `DEPTH` (default 4) stack entries are in use, and when `DEPTH` interrupts are still active. In either case `irq_out` is 0 and an acknowledge read returns 1023.
- R12: Each drop restores the running priority that held before the matching acknowledge. Nested interrupts unwind in order down to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_valid | input | 1 | Distributor has a pending candidate |
| hp_id | input | 10 | Candidate interrupt ID |
| hp_prio | input | 8 | Candidate priority (lower is higher) |
| hp_group | input | 1 | Candidate group (0 or 1) |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_rvalid | output | 1 | Acknowledge read data valid |
| ack_rdata | output | 10 | Acknowledged ID or 1023 |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID being ended |
| dir_wr | input | 1 | Deactivate write strobe |
| dir_id | input | 10 | ID being deactivated |
| pmr_wr | input | 1 | Priority mask write strobe |
| pmr_wdata | input | 8 | New priority mask |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | [0] group 0 enable, [1] group 1 enable, [2] split mode, [3] clear error |
| irq_out | output | 1 | Interrupt request to the processor |
| run_prio | output | 8 | Current running priority |
| err_flag | output | 1 | Sticky bad end-of-interrupt flag |
| dist_ack_vld | output | 1 | Acknowledge event to distributor |
| dist_ack_id | output | 10 | ID of the acknowledge event |
| dist_deact_vld | output | 1 | Deactivate event to distributor |
| dist_deact_id | output | 10 | ID of the deactivate event |

## Verification
The hardest condition to reach is an exhausted active table while the stack is empty and the running priority is idle. In that state every guard except room passes, yet `irq_out` must stay low. The stimulus gets there in split mode: it acknowledges and drops four interrupts in turn and never deactivates any of them. It then offers a fifth candidate, checks that the acknowledge read comes back spurious, and confirms that one deactivate write brings the request back. The stack-full case is reached by nesting four acknowledges, each with a strictly higher priority than the one before. A mismatched end-of-interrupt write is then issued at the full depth, so both the error flag and the preserved running priority are checked there.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
    localparam int ID_W     = 10;
    localparam int PRIO_W   = 8;
    localparam int CTL_W    = 4;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = ID_W'(1023);
    localparam logic [PRIO_W-1:0] PRIO_IDLE   = '1;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_PART,
        ST_FULL
    } stk_state_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } frame_t;
endpackage

// File: rtl/cpuif_prio_stack.sv
module cpuif_prio_stack
    import cpuif_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  frame_t push_frame,
    input  logic   pop,
    output frame_t top_frame,
    output logic   empty,
    output logic   full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stk_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    frame_t frames_q [DEPTH];

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (push) state_d = (DEPTH == 1) ? ST_FULL : ST_PART;
            ST_PART: begin
                if (push && cnt_q == CW'(DEPTH - 1)) state_d = ST_FULL;
                else if (pop && cnt_q == CW'(1))     state_d = ST_EMPTY;
            end
            ST_FULL:  if (pop) state_d = (DEPTH == 1) ? ST_EMPTY : ST_PART;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // storage and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) frames_q[i] <= '0;
        end else if (push && state_q != ST_FULL) begin
            frames_q[IW'(cnt_q)] <= push_frame;
            cnt_q <= cnt_q + CW'(1);
        end else if (pop && state_q != ST_EMPTY) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // outputs
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        top_frame = frames_q[IW'(cnt_q - CW'(1))];
        unique case (state_q)
            ST_EMPTY: begin
                empty = 1'b1;
                top_frame = '{id: SPURIOUS_ID, prio: PRIO_IDLE};
            end
            ST_PART:  ;
            ST_FULL:  full = 1'b1;
            default:  empty = 1'b1;
        endcase
    end
endmodule

// File: rtl/cpuif_active_tbl.sv
module cpuif_active_tbl
    import cpuif_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic [ID_W-1:0] alloc_id,
    input  logic            rel,
    input  logic [ID_W-1:0] rel_id,
    output logic            rel_hit,
    output logic            has_free
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic            valid_q [SLOTS];
    logic [ID_W-1:0] ids_q   [SLOTS];
    logic [SW-1:0]   hit_idx, free_idx;

    always_comb begin
        rel_hit  = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (valid_q[i] && ids_q[i] == rel_id) begin
                rel_hit = 1'b1;
                hit_idx = SW'(i);
            end
            if (!valid_q[i]) begin
                has_free = 1'b1;
                free_idx = SW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                valid_q[i] <= 1'b0;
                ids_q[i]   <= '0;
            end
        end else begin
            if (rel && rel_hit) valid_q[hit_idx] <= 1'b0;
            if (alloc && has_free) begin
                valid_q[free_idx] <= 1'b1;
                ids_q[free_idx]   <= alloc_id;
            end
        end
    end
endmodule

// File: rtl/cpuif_signal.sv
module cpuif_signal
    import cpuif_pkg::*;
(
    input  logic              hp_valid,
    input  logic              hp_group,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic [1:0]        grp_en,
    input  logic [PRIO_W-1:0] pmr,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              room,
    output logic              irq
);
    logic grp_ok, mask_ok, preempt_ok;

    always_comb begin
        grp_ok     = grp_en[hp_group];
        mask_ok    = hp_prio < pmr;
        preempt_ok = hp_prio < run_prio;
        irq        = hp_valid && grp_ok && mask_ok && preempt_ok && room;
    end
endmodule

// File: rtl/cpuif_ack_eoi.sv
module cpuif_ack_eoi
    import cpuif_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_valid,
    input  logic [ID_W-1:0]   hp_id,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic              hp_group,
    input  logic              ack_rd,
    output logic              ack_rvalid,
    output logic [ID_W-1:0]   ack_rdata,
    input  logic              eoi_wr,
    input  logic [ID_W-1:0]   eoi_id,
    input  logic              dir_wr,
    input  logic [ID_W-1:0]   dir_id,
    input  logic              pmr_wr,
    input  logic [PRIO_W-1:0] pmr_wdata,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic              irq_out,
    output logic [PRIO_W-1:0] run_prio,
    output logic              err_flag,
    output logic              dist_ack_vld,
    output logic [ID_W-1:0]   dist_ack_id,
    output logic              dist_deact_vld,
    output logic [ID_W-1:0]   dist_deact_id
);
    logic [PRIO_W-1:0] pmr_q;
    logic [1:0]        grp_en_q;
    logic              split_q;
    logic              err_q;

    frame_t          top_frame;
    logic            stk_empty, stk_full;
    logic            act_hit, act_free;
    logic            ack_take, eoi_sel, eoi_hit, eoi_bad, dir_do, release_en;
    logic [ID_W-1:0] rel_id;

    assign run_prio = top_frame.prio;
    assign err_flag = err_q;

    cpuif_signal u_sig (
        .hp_valid (hp_valid),
        .hp_group (hp_group),
        .hp_prio  (hp_prio),
        .grp_en   (grp_en_q),
        .pmr      (pmr_q),
        .run_prio (run_prio),
        .room     (!stk_full && act_free),
        .irq      (irq_out)
    );

    always_comb begin
        ack_take   = ack_rd && irq_out;
        eoi_sel    = !ack_rd && eoi_wr;
        eoi_hit    = eoi_sel && !stk_empty && eoi_id == top_frame.id;
        eoi_bad    = eoi_sel && !eoi_hit;
        rel_id     = eoi_sel ? eoi_id : dir_id;
        dir_do     = !ack_rd && !eoi_wr && dir_wr && split_q && act_hit;
        release_en = (eoi_hit && !split_q) || dir_do;
    end

    cpuif_prio_stack #(.DEPTH(DEPTH)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (ack_take),
        .push_frame ('{id: hp_id, prio: hp_prio}),
        .pop        (eoi_hit),
        .top_frame  (top_frame),
        .empty      (stk_empty),
        .full       (stk_full)
    );

    cpuif_active_tbl #(.SLOTS(DEPTH)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (ack_take),
        .alloc_id (hp_id),
        .rel      (release_en),
        .rel_id   (rel_id),
        .rel_hit  (act_hit),
        .has_free (act_free)
    );

    // configuration and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmr_q    <= '0;
            grp_en_q <= '0;
            split_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (pmr_wr) pmr_q <= pmr_wdata;
            if (ctl_wr) begin
                grp_en_q <= ctl_wdata[1:0];
                split_q  <= ctl_wdata[2];
            end
            if (eoi_bad)                    err_q <= 1'b1;
            else if (ctl_wr && ctl_wdata[3]) err_q <= 1'b0;
        end
    end

    // responses and distributor events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_rvalid     <= 1'b0;
            ack_rdata      <= '0;
            dist_ack_vld   <= 1'b0;
            dist_ack_id    <= '0;
            dist_deact_vld <= 1'b0;
            dist_deact_id  <= '0;
        end else begin
            ack_rvalid     <= ack_rd;
            ack_rdata      <= ack_take ? hp_id : SPURIOUS_ID;
            dist_ack_vld   <= ack_take;
            dist_ack_id    <= hp_id;
            dist_deact_vld <= release_en;
            dist_deact_id  <= rel_id;
        end
    end
endmodule

// File: rtl/cpuif_ack_eoi_chk.sv
module cpuif_ack_eoi_chk
    import cpuif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hp_valid,
    input logic [PRIO_W-1:0] hp_prio,
    input logic              ack_rd,
    input logic              ack_rvalid,
    input logic [ID_W-1:0]   ack_rdata,
    input logic              eoi_wr,
    input logic              dir_wr,
    input logic              ctl_wr,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic              irq_out,
    input logic [PRIO_W-1:0] run_prio,
    input logic [PRIO_W-1:0] pmr,
    input logic              err_flag,
    input logic              dist_ack_vld,
    input logic              dist_deact_vld
);
    p_irq_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> hp_valid);

    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> hp_prio < pmr);

    p_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> hp_prio < run_prio);

    p_ack_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq_out) |=> (ack_rvalid && dist_ack_vld && run_prio == $past(hp_prio)));

    p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !irq_out) |=> (ack_rvalid && !dist_ack_vld && ack_rdata == SPURIOUS_ID));

    p_deact_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dist_deact_vld |-> $past(eoi_wr || dir_wr));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(ctl_wr && ctl_wdata[3])) |=> err_flag);

    p_no_ack_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_rd && !eoi_wr) |=> $stable(run_prio));
endmodule

bind cpuif_ack_eoi cpuif_ack_eoi_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hp_valid       (hp_valid),
    .hp_prio        (hp_prio),
    .ack_rd         (ack_rd),
    .ack_rvalid     (ack_rvalid),
    .ack_rdata      (ack_rdata),
    .eoi_wr         (eoi_wr),
    .dir_wr         (dir_wr),
    .ctl_wr         (ctl_wr),
    .ctl_wdata      (ctl_wdata),
    .irq_out        (irq_out),
    .run_prio       (run_prio),
    .pmr            (pmr_q),
    .err_flag       (err_flag),
    .dist_ack_vld   (dist_ack_vld),
    .dist_deact_vld (dist_deact_vld)
);

// File: tb/tb_cpuif_ack_eoi.sv
`timescale 1ns/1ps
module tb_cpuif_ack_eoi;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hp_valid = 1'b0;
    logic [9:0] hp_id = '0;
    logic [7:0] hp_prio = 8'hFF;
    logic       hp_group = 1'b0;
    logic       ack_rd = 1'b0;
    logic       ack_rvalid;
    logic [9:0] ack_rdata;
    logic       eoi_wr = 1'b0;
    logic [9:0] eoi_id = '0;
    logic       dir_wr = 1'b0;
    logic [9:0] dir_id = '0;
    logic       pmr_wr = 1'b0;
    logic [7:0] pmr_wdata = '0;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic       irq_out;
    logic [7:0] run_prio;
    logic       err_flag;
    logic       dist_ack_vld;
    logic [9:0] dist_ack_id;
    logic       dist_deact_vld;
    logic [9:0] dist_deact_id;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int ack_q[$];
    int deact_q[$];

    always #4 clk = ~clk;

    cpuif_ack_eoi dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: scoreboard compare of acknowledge and deactivate results
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ack_rvalid) begin
                if (ack_q.size() == 0) check("R5 unexpected ack response", 1, 0);
                else begin
                    int e;
                    e = ack_q.pop_front();
                    check("R5/R6 ack_rdata", int'(ack_rdata), e);
                    check("R5/R6 dist_ack_vld", int'(dist_ack_vld), (e != 1023) ? 1 : 0);
                    if (e != 1023) check("R5 dist_ack_id", int'(dist_ack_id), e);
                end
            end
            if (dist_deact_vld) begin
                if (deact_q.size() == 0) check("R8/R9 unexpected deactivate", int'(dist_deact_id), -1);
                else check("R7/R8 deact id", int'(dist_deact_id), deact_q.pop_front());
            end
        end
    end

    task automatic pulse_end();
        @(negedge clk);
        ack_rd = 0; eoi_wr = 0; dir_wr = 0; pmr_wr = 0; ctl_wr = 0;
        #1;
    endtask

    task automatic do_ack(input int exp_id);
        @(negedge clk);
        ack_q.push_back(exp_id);
        ack_rd = 1;
        pulse_end();
    endtask

    task automatic do_eoi(input int id, input bit exp_deact);
        @(negedge clk);
        if (exp_deact) deact_q.push_back(id);
        eoi_id = 10'(id); eoi_wr = 1;
        pulse_end();
    endtask

    task automatic do_dir(input int id, input bit exp_deact);
        @(negedge clk);
        if (exp_deact) deact_q.push_back(id);
        dir_id = 10'(id); dir_wr = 1;
        pulse_end();
    endtask

    task automatic wr_pmr(input int v);
        @(negedge clk);
        pmr_wdata = 8'(v); pmr_wr = 1;
        pulse_end();
    endtask

    task automatic wr_ctl(input int v);
        @(negedge clk);
        ctl_wdata = 4'(v); ctl_wr = 1;
        pulse_end();
    endtask

    task automatic offer(input int id, input int prio, input bit grp);
        @(negedge clk);
        hp_valid = 1; hp_id = 10'(id); hp_prio = 8'(prio); hp_group = grp;
        #1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 irq_out after reset", int'(irq_out), 0);
        check("R1 run_prio after reset", int'(run_prio), 8'hFF);
        check("R1 err_flag after reset", int'(err_flag), 0);
        @(negedge clk);
        rst_n = 1;
        offer(40, 8'h80, 1);
        check("R1 mask 0 blocks", int'(irq_out), 0);
        wr_pmr(8'hF0);
        check("R2 groups disabled", int'(irq_out), 0);
        do_ack(1023);
        check("R6 run_prio kept", int'(run_prio), 8'hFF);
        wr_ctl(1);
        check("R2 only group0 enabled, group1 candidate", int'(irq_out), 0);
        wr_ctl(3);
        check("R2 group1 enabled", int'(irq_out), 1);
        @(negedge clk); hp_valid = 0; #1;
        check("R2 no valid candidate", int'(irq_out), 0);
        @(negedge clk); hp_valid = 1; #1;
        wr_pmr(8'h80);
        check("R3 prio equal to mask blocked", int'(irq_out), 0);
        wr_pmr(8'h81);
        check("R3 prio below mask passes", int'(irq_out), 1);
        wr_pmr(8'hF0);

        // nested acknowledges up to a full stack
        do_ack(40);
        check("R5 run_prio after ack 40", int'(run_prio), 8'h80);
        offer(41, 8'h80, 1);
        check("R4 equal priority no preempt", int'(irq_out), 0);
        offer(41, 8'h7F, 1);
        check("R4 higher priority preempts", int'(irq_out), 1);
        do_ack(41);
        offer(42, 8'h40, 0);
        do_ack(42);
        offer(43, 8'h20, 1);
        do_ack(43);
        check("R5 run_prio after four acks", int'(run_prio), 8'h20);
        offer(44, 8'h10, 1);
        check("R11 stack full blocks irq", int'(irq_out), 0);
        do_ack(1023);

        // mismatched end of interrupt
        do_eoi(42, 0);
        check("R10 err set on mismatch", int'(err_flag), 1);
        check("R10 run_prio kept on mismatch", int'(run_prio), 8'h20);

        // combined-mode unwinding
        @(negedge clk); hp_valid = 0; #1;
        do_eoi(43, 1);
        check("R12 drop to 0x40", int'(run_prio), 8'h40);
        do_eoi(42, 1);
        check("R12 drop to 0x7F", int'(run_prio), 8'h7F);
        do_eoi(41, 1);
        check("R12 drop to 0x80", int'(run_prio), 8'h80);
        do_eoi(40, 1);
        check("R7 drop to idle", int'(run_prio), 8'hFF);
        check("R10 err still set", int'(err_flag), 1);
        wr_ctl(4'b1011);
        check("R10 err cleared", int'(err_flag), 0);
        do_eoi(5, 0);
        check("R10 err on empty stack eoi", int'(err_flag), 1);
        wr_ctl(4'b1011);

        // combined mode: deactivate write ignored
        offer(70, 8'h30, 0);
        do_ack(70);
        do_dir(70, 0);
        repeat (2) @(negedge clk);
        check("R9 deactivate ignored in combined mode", deact_q.size(), 0);
        do_eoi(70, 1);

        // split mode
        wr_ctl(4'b0111);
        offer(50, 8'h30, 1);
        do_ack(50);
        do_eoi(50, 0);
        check("R8 split drop only", int'(run_prio), 8'hFF);
        do_dir(51, 0);
        do_dir(50, 1);
        do_dir(50, 0);
        repeat (2) @(negedge clk);
        check("R9 no stray deactivate", deact_q.size(), 0);

        // exhaust active table with dropped but undeactivated interrupts
        for (int k = 0; k < 4; k++) begin
            offer(60 + k, 8'h30, 1);
            do_ack(60 + k);
            do_eoi(60 + k, 0);
        end
        offer(64, 8'h30, 1);
        check("R11 active table full blocks irq", int'(irq_out), 0);
        check("R11 run_prio idle", int'(run_prio), 8'hFF);
        do_ack(1023);
        do_dir(60, 1);
        check("R11 room restored after deactivate", int'(irq_out), 1);
        for (int k = 1; k < 4; k++) do_dir(60 + k, 1);
        repeat (3) @(negedge clk);
        check("R8 all expected deactivates seen", deact_q.size(), 0);
        check("R5 all expected acks seen", ack_q.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule